// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through

This block carries 36-bit words from one clock domain to another. The writer and the reader each run on their own clock. The two clocks may be unrelated, or they may be the same net. A word is transferred on the rising edge of a port's clock, and only when that port's enable is high. Each side has a single status pin. The meaning of that pin depends on a mode input, which is captured while reset is held.

In standard mode, the write-side pin reports *full* and the read-side pin reports *empty*. A stored word reaches the data output only after a read is accepted. In fall-through mode, the write-side pin reports *ready to accept* and the read-side pin reports *output holds valid data*. The oldest stored word moves into an output register without any request, so it is already visible on the output when the reader wants it. Each later word still needs a read to advance the output.

Pointers cross between the domains as Gray code through a configurable chain of synchronising flops. This makes the flags conservative: they clear a few cycles late, and they never clear early. The depth is a power of two, with 256, 512 and 1024 as the intended sizes.

Top module: `dcfifo_top`

## Requirements
- R1: A word is taken only on a rising `wr_clk` edge with `wr_en` high. Changes on `wr_data` while `wr_en` is low store nothing.
- R2: Both resets are synchronous and active low. After reset, `rd_data` is 0. In standard mode `wr_flag`=0 (not full) and `rd_flag`=1 (empty). In fall-through mode `wr_flag`=1 (ready) and `rd_flag`=0 (no valid data).
- R3: In standard mode a written word does not reach `rd_data` until a read is accepted. A read accepted on a `rd_clk` edge presents the word on `rd_data` right after that same edge. `rd_flag` rises only after an accepted read.
- R4: In fall-through mode the first word written into an empty FIFO appears on `rd_data`, and `rd_flag` rises, with `rd_en` held low.
- R5: In fall-through mode, while `rd_flag`=1 and `rd_en`=0, `rd_data` and `rd_flag` hold. A read accepted on an edge advances the output to the next word, or clears `rd_flag` if no word is stored.
- R6: Words leave in the order in which they were accepted. This holds when reads and writes run at the same time on unrelated clocks.
- R7: In standard mode `wr_flag` goes to 1 once DEPTH words are stored. In fall-through mode `wr_flag` goes to 0 once the memory holds DEPTH words, in addition to the word in the output register. `wr_flag` becomes "full" only after an accepted write.
- R8: A write attempted while full (or not ready) is dropped and leaves the write pointer unchanged.
- R9: A read attempted while empty (or while `rd_flag`=0 in fall-through mode) is dropped. It leaves the read pointer and `rd_data` unchanged.
- R10: `fwft_sel` (1 = fall-through, 0 = standard) is sampled only while reset is low. Changing it afterwards has no effect on flag meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_flag | output | 1 | Full (standard) or ready to accept (fall-through) |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| fwft_sel | input | 1 | Mode select, captured during reset |

## Verification
Two functions can coincide on the same read edge in fall-through mode: a read consumes the output register, and that register is reloaded from memory at the same time. In either mode, a write and a read can also land together while the Gray pointers are in flight between the domains. The bench provokes both cases by running a back-to-back write burst in parallel with a long read-enable window. The write clock runs at 8 ns and the read clock at 12 ns, so the edges drift against each other. Every word accepted by the writer goes into a scoreboard queue. Every word the monitor sees leave must match the head of that queue, and the queue must be empty once the FIFO has drained.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-clock FIFO.
// Assumes: nothing; pure constants and types.
package dcf_pkg;
    localparam int unsigned WORD_W = 36;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a Gray-coded pointer.
// Assumes: the input changes by at most one bit per source clock.
module dcf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // shift the pointer through the synchronising stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
// Write-side pointer and full detection.
// Assumes: AW >= 2; rgray_s is the read pointer already synchronised to clk.
module dcf_wr_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          accept,
    output logic          full
);
    logic [AW:0] bin_q;
    logic [AW:0] bin_nx;

    // full when the pointers differ only in the two top Gray bits
    assign full   = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign accept = wr_en && !full;
    assign bin_nx = bin_q + {{AW{1'b0}}, accept};
    assign waddr  = bin_q[AW-1:0];

    // advance binary and Gray write pointers on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q <= '0;
            wgray <= '0;
        end else begin
            bin_q <= bin_nx;
            wgray <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side pointer, empty detection and output-valid tracking.
// Assumes: wgray_s is the write pointer synchronised to clk; fwft is static.
module dcf_rd_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          fwft,
    input  logic [AW:0]   wgray_s,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          fetch,
    output logic          mem_empty,
    output logic          out_valid
);
    logic [AW:0] bin_q;
    logic [AW:0] bin_nx;

    assign mem_empty = (rgray == wgray_s);
    assign raddr     = bin_q[AW-1:0];
    assign bin_nx    = bin_q + {{AW{1'b0}}, fetch};

    // decide whether memory is read this cycle
    always_comb begin
        if (fwft) fetch = !mem_empty && (!out_valid || rd_en);
        else      fetch = !mem_empty && rd_en;
    end

    // advance binary and Gray read pointers on a fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q <= '0;
            rgray <= '0;
        end else begin
            bin_q <= bin_nx;
            rgray <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // track whether the output register holds an unread word
    always_ff @(posedge clk) begin
        if (!rst_n)     out_valid <= 1'b0;
        else if (fetch) out_valid <= 1'b1;
        else if (rd_en) out_valid <= 1'b0;
    end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
// Two-clock storage array with a registered, enabled read port.
// Assumes: caller never writes and reads one address in the same instant.
module dcf_mem #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [DW-1:0] store [N];

    // write port
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // registered read port, cleared by reset
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/dcfifo_top.sv
`timescale 1ns/1ps
// Dual-clock FIFO with standard or fall-through read behaviour.
// Assumes: DEPTH is a power of two and at least 4; fwft_sel is stable
// while either reset is released; resets are held for several cycles
// of both clocks.
module dcfifo_top #(
    parameter int DATA_W      = dcf_pkg::WORD_W,
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_flag,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    input  logic              fwft_sel
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    dcf_pkg::fifo_mode_e mode_wr_q;
    dcf_pkg::fifo_mode_e mode_rd_q;
    logic                fw_wr;
    logic                fw_rd;

    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] wr_gray_s;
    logic [PW-1:0] rd_gray_s;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic          wr_accept;
    logic          wr_full;
    logic          rd_fetch;
    logic          rd_empty;
    logic          out_valid;

    // capture the mode in the write domain while reset is held
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) mode_wr_q <= dcf_pkg::fifo_mode_e'(fwft_sel);
    end

    // capture the mode in the read domain while reset is held
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) mode_rd_q <= dcf_pkg::fifo_mode_e'(fwft_sel);
    end

    assign fw_wr = (mode_wr_q == dcf_pkg::MODE_FWFT);
    assign fw_rd = (mode_rd_q == dcf_pkg::MODE_FWFT);

    dcf_wr_ctrl #(.AW(AW)) wr_ctrl_i (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .wr_en   (wr_en),
        .rgray_s (rd_gray_s),
        .waddr   (waddr),
        .wgray   (wr_gray),
        .accept  (wr_accept),
        .full    (wr_full)
    );

    dcf_rd_ctrl #(.AW(AW)) rd_ctrl_i (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .rd_en     (rd_en),
        .fwft      (fw_rd),
        .wgray_s   (wr_gray_s),
        .raddr     (raddr),
        .rgray     (rd_gray),
        .fetch     (rd_fetch),
        .mem_empty (rd_empty),
        .out_valid (out_valid)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_i (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_i (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    dcf_mem #(.AW(AW), .DW(DATA_W)) mem_i (
        .wclk  (wr_clk),
        .we    (wr_accept),
        .waddr (waddr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .rst_n (rd_rst_n),
        .re    (rd_fetch),
        .raddr (raddr),
        .rdata (rd_data)
    );

    // status pins change meaning with the captured mode
    assign wr_flag = fw_wr ? !wr_full : wr_full;
    assign rd_flag = fw_rd ? out_valid : rd_empty;
endmodule

// File: rtl/dcfifo_chk.sv
`timescale 1ns/1ps
// Property checker bound to dcfifo_top.
// Assumes: connected through the bind below.
module dcfifo_chk #(
    parameter int DATA_W = 36,
    parameter int PW     = 9
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_full,
    input logic [PW-1:0]     wr_gray,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_en,
    input logic              rd_empty,
    input logic              rd_flag,
    input logic [DATA_W-1:0] rd_data,
    input logic              fw_rd,
    input logic [PW-1:0]     rd_gray
);
    AST_FULL_AFTER_WRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(wr_full) |-> $past(wr_en)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full && wr_en) |=> $stable(wr_gray)); // R8

    AST_WPTR_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fw_rd && rd_empty && rd_en) |=> $stable(rd_gray)); // R9

    AST_EMPTY_AFTER_READ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fw_rd && $rose(rd_empty)) |-> $past(rd_en)); // R3

    AST_HEAD_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fw_rd && rd_flag && !rd_en) |=> ($stable(rd_data) && rd_flag)); // R5

    AST_VALID_DROP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fw_rd && $fell(rd_flag)) |-> $past(rd_en)); // R5
endmodule

bind dcfifo_top dcfifo_chk #(.DATA_W(DATA_W), .PW(PW)) chk_i (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_en    (wr_en),
    .wr_full  (wr_full),
    .wr_gray  (wr_gray),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_empty (rd_empty),
    .rd_flag  (rd_flag),
    .rd_data  (rd_data),
    .fw_rd    (fw_rd),
    .rd_gray  (rd_gray)
);

// File: tb/dcfifo_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: writers push accepted words, a read monitor pops and compares.
module dcfifo_top_tb_top;
    localparam int DW    = 36;
    localparam int DEPTH = 16;

    logic          wr_clk   = 1'b0;
    logic          rd_clk   = 1'b0;
    logic          rst_n    = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          wr_en    = 1'b0;
    logic          rd_en    = 1'b0;
    logic [DW-1:0] wr_data  = '0;
    logic [DW-1:0] rd_data;
    logic          wr_flag;
    logic          rd_flag;

    int            total   = 0;
    int            bad     = 0;
    bit            mode_fw = 1'b0;
    bit            mon_on  = 1'b0;
    bit            pend    = 1'b0;
    bit            done    = 1'b0;
    logic [DW-1:0] exp_q [$];

    always #4 wr_clk = ~wr_clk;   // 125 MHz write clock
    always #6 rd_clk = ~rd_clk;   // unrelated, slower read clock

    dcfifo_top #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_flag  (wr_flag),
        .rd_clk   (rd_clk),
        .rd_rst_n (rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_flag  (rd_flag),
        .fwft_sel (fwft_sel)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pop_cmp();
        logic [DW-1:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected word", rd_data, '0);
        end else begin
            e = exp_q.pop_front();
            check(rd_data === e, "R6 order", rd_data, e);
        end
    endtask

    // monitor: pops expected words as the design presents them
    always @(negedge rd_clk) begin
        if (!mon_on) begin
            pend = 1'b0;
        end else if (!mode_fw) begin
            if (pend) pop_cmp();
            pend = rd_en && !rd_flag;
        end else if (rd_en && rd_flag) begin
            pop_cmp();
        end
    end

    task automatic settle();
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic do_reset(input bit fw);
        mon_on = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        rst_n = 1'b0; fwft_sel = fw; mode_fw = fw;
        exp_q.delete();
        repeat (4) @(posedge rd_clk);
        repeat (4) @(posedge wr_clk);
        @(posedge wr_clk); #1; rst_n = 1'b1;
        @(negedge rd_clk); mon_on = 1'b1;
    endtask

    // driver: back-to-back writes, accepted words go to the scoreboard
    task automatic wr_burst(input int n, input logic [DW-1:0] base, output int acc);
        acc = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge wr_clk); #2; wr_en = 1'b1; wr_data = base + DW'(i);
            @(negedge wr_clk);
            if (mode_fw ? wr_flag : !wr_flag) begin
                exp_q.push_back(wr_data);
                acc++;
            end
        end
        @(posedge wr_clk); #2; wr_en = 1'b0;
    endtask

    task automatic rd_hold(input int n);
        @(posedge rd_clk); #2; rd_en = 1'b1;
        repeat (n) @(posedge rd_clk);
        #2; rd_en = 1'b0;
    endtask

    initial begin
        int acc;
        int acc2;
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        check(wr_flag == 1'b0, "R2 std full after reset", DW'(wr_flag), 0);
        check(rd_flag == 1'b1, "R2 std empty after reset", DW'(rd_flag), 1);
        check(rd_data == '0, "R2 rd_data after reset", rd_data, '0);

        fwft_sel = 1'b1;  // R10: must be ignored after reset
        settle();
        check(wr_flag == 1'b0 && rd_flag == 1'b1, "R10 mode change ignored",
              DW'({wr_flag, rd_flag}), DW'(2'b01));

        rd_hold(3);       // R9: reads while empty
        settle();
        check(rd_data == '0, "R9 read while empty", rd_data, '0);

        wr_burst(1, 36'hA_5A5A_0001, acc);
        settle();
        check(rd_flag == 1'b0, "R3 not empty after write", DW'(rd_flag), 0);
        check(rd_data == '0, "R3 word waits for read", rd_data, '0);
        rd_hold(1);
        settle();
        check(rd_data == 36'hA_5A5A_0001, "R3 word after read", rd_data, 36'hA_5A5A_0001);
        check(rd_flag == 1'b1, "R3 empty after read", DW'(rd_flag), 1);

        for (int i = 0; i < 5; i++) begin   // R1: data moves with enable low
            @(posedge wr_clk); #2; wr_data = DW'(i * 7 + 3);
        end
        settle();
        check(rd_flag == 1'b1, "R1 no write without enable", DW'(rd_flag), 1);

        wr_burst(DEPTH + 3, 36'h1_0000_0000, acc);
        settle();
        check(acc == DEPTH, "R8 std writes beyond full dropped", DW'(acc), DW'(DEPTH));
        check(wr_flag == 1'b1, "R7 std full flag", DW'(wr_flag), 1);
        rd_hold(DEPTH + 4);
        settle();
        check(exp_q.size() == 0 && rd_flag == 1'b1, "R8 std drain exact", DW'(exp_q.size()), 0);

        fork
            wr_burst(40, 36'h2_0000_0000, acc);
            rd_hold(60);
        join
        rd_hold(DEPTH + 4);
        settle();
        check(exp_q.size() == 0, "R6 std concurrent drain", DW'(exp_q.size()), 0);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        check(wr_flag == 1'b1, "R2 fwft ready after reset", DW'(wr_flag), 1);
        check(rd_flag == 1'b0, "R2 fwft no valid after reset", DW'(rd_flag), 0);

        wr_burst(1, 36'h3_0000_00AA, acc);
        settle();
        check(rd_flag == 1'b1, "R4 valid without read", DW'(rd_flag), 1);
        check(rd_data == 36'h3_0000_00AA, "R4 first word falls through", rd_data, 36'h3_0000_00AA);

        wr_burst(1, 36'h3_0000_00BB, acc);
        settle();
        check(rd_data == 36'h3_0000_00AA, "R5 head held without read", rd_data, 36'h3_0000_00AA);
        rd_hold(1);
        settle();
        check(rd_data == 36'h3_0000_00BB && rd_flag, "R5 next word after read", rd_data, 36'h3_0000_00BB);
        rd_hold(1);
        settle();
        check(rd_flag == 1'b0, "R5 valid clears when drained", DW'(rd_flag), 0);
        rd_hold(3);       // R9: reads while not valid
        settle();
        check(exp_q.size() == 0 && rd_flag == 1'b0, "R9 fwft read while not valid", DW'(rd_flag), 0);

        wr_burst(1, 36'h4_0000_0000, acc);
        settle();
        wr_burst(DEPTH + 3, 36'h4_0000_0001, acc2);
        settle();
        check(acc2 == DEPTH, "R8 fwft writes beyond full dropped", DW'(acc2), DW'(DEPTH));
        check(wr_flag == 1'b0, "R7 fwft not ready when full", DW'(wr_flag), 0);
        rd_hold(DEPTH + 4);
        settle();
        check(exp_q.size() == 0 && rd_flag == 1'b0, "R7 fwft capacity drain", DW'(exp_q.size()), 0);

        fork
            wr_burst(40, 36'h5_0000_0000, acc);
            rd_hold(60);
        join
        rd_hold(DEPTH + 4);
        settle();
        check(exp_q.size() == 0, "R6 fwft concurrent drain", DW'(exp_q.size()), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule